// File: doc/BRIEF.md
# Legacy PC Physical Address Router

This block sits between a byte-wide requester and the memories and devices of a classic PC-style physical address space. Each cycle it may receive one byte read or write carrying a 32-bit physical address. It works out which target window the address lies in and raises that target's select line. It passes the target an offset relative to the window's base, and it forwards the write strobe and the write data.

The fixed windows below 1 MB cover conventional RAM, display memory, the option-ROM/device area and the boot ROM. Above 1 MB there is an extended RAM window whose size is a parameter. A device window sits at the top of the 4 GB space. Writes aimed at the boot ROM never reach it. Addresses in the gap between extended RAM and the device window select nothing and are reported as a decode miss.

The select, offset and write strobe are combinational from the request. The target returns read data in the same cycle. The router registers the response and presents it exactly one cycle after the request.

Top module: `mem_region_router`

## Requirements
- R1: Addresses 0x00000000..0x0009FFFF assert tgt_sel bit 0 (conventional RAM), with tgt_offset equal to the address.
- R2: Addresses 0x000A0000..0x000BFFFF assert tgt_sel bit 1 (display memory), with tgt_offset = address - 0x000A0000.
- R3: Addresses 0x000C0000..0x000EFFFF assert tgt_sel bit 2 (option ROM/device area), with tgt_offset = address - 0x000C0000.
- R4: Addresses 0x000F0000..0x000FFFFF assert tgt_sel bit 3 (boot ROM), with tgt_offset = address - 0x000F0000. Reads are served normally. A write there keeps tgt_wr low, and a later read of the same location returns the target's data unchanged.
- R5: Addresses 0x00100000..0x00100000+EXT_BYTES-1 assert tgt_sel bit 4 (extended RAM), with tgt_offset = address - 0x00100000. EXT_BYTES defaults to 10 MB, so the window ends at 0x00AFFFFF.
- R6: Addresses DEV_BASE..0xFFFFFFFF assert tgt_sel bit 5 (device window), with tgt_offset = address - DEV_BASE. DEV_BASE defaults to 0xFE000000.
- R7: An address in no window asserts no select and keeps tgt_wr low. One cycle later rsp_miss is high, and for a read rsp_rdata is 0xFF.
- R8: At most one tgt_sel bit is high at any time. All bits are low when req_valid is low. tgt_wr is high only for a valid write to a mapped window other than the boot ROM, and tgt_wdata equals req_wdata.
- R9: rsp_valid is high in exactly the cycle after each cycle with req_valid high. For a read hit, rsp_rdata is the selected target's slot of tgt_rdata (bits 8*i+7..8*i for select bit i) as sampled in the request cycle. For a write, rsp_rdata is 0x00.
- R10: While rst is high, rsp_valid and rsp_miss are low and rsp_rdata is 0x00 on the next clock, even if a request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 8 | Write byte |
| tgt_sel | output | 6 | One-hot target select |
| tgt_wr | output | 1 | Write strobe to the selected target |
| tgt_offset | output | 32 | Address relative to the selected window's base |
| tgt_wdata | output | 8 | Write byte to targets |
| tgt_rdata | input | 48 | Read bytes from the six targets, slot i at bits 8*i+7..8*i |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 8 | Read result |
| rsp_miss | output | 1 | The request hit no window |

## Verification
The bench goes after the first and last byte of every window, including the gap bytes that sit directly past extended RAM and directly below the device window. An off-by-one boundary shows up there as the wrong select bit, or as a miss where a hit belongs, or the reverse. A write aimed at the boot ROM is followed by a read of the same byte. A design that leaks the strobe raises tgt_wr, and a bench-side target model would then return the altered value. A swapped base subtraction shows up as a wrong offset and therefore as wrong returned data. Back-to-back requests, idle gaps and requests held during reset catch a response that arrives at the wrong time or survives reset.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int NREG = 6;
  typedef enum int {
    RG_LOW = 0,
    RG_VGA = 1,
    RG_OPT = 2,
    RG_ROM = 3,
    RG_EXT = 4,
    RG_DEV = 5
  } region_e;
endpackage

// File: rtl/addr_decoder.sv
module addr_decoder
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned EXT_BYTES = 10 * 1024 * 1024,
  parameter logic [31:0] DEV_BASE  = 32'hFE00_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  localparam logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(32'h0010_0000);
  localparam logic [ADDR_W-1:0] EXT_LAST = EXT_BASE + ADDR_W'(EXT_BYTES) - 1'b1;

  function automatic logic [ADDR_W-1:0] base_of(int idx);
    case (idx)
      RG_LOW:  return '0;
      RG_VGA:  return ADDR_W'(32'h000A_0000);
      RG_OPT:  return ADDR_W'(32'h000C_0000);
      RG_ROM:  return ADDR_W'(32'h000F_0000);
      RG_EXT:  return EXT_BASE;
      default: return ADDR_W'(DEV_BASE);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] last_of(int idx);
    case (idx)
      RG_LOW:  return ADDR_W'(32'h0009_FFFF);
      RG_VGA:  return ADDR_W'(32'h000B_FFFF);
      RG_OPT:  return ADDR_W'(32'h000E_FFFF);
      RG_ROM:  return ADDR_W'(32'h000F_FFFF);
      RG_EXT:  return EXT_LAST;
      default: return '1;
    endcase
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_win
    if (i == 0) begin : g_first
      assign sel[i] = (addr <= last_of(i));
    end else if (i == NREG - 1) begin : g_top
      assign sel[i] = (addr >= base_of(i));
    end else begin : g_mid
      assign sel[i] = (addr >= base_of(i)) && (addr <= last_of(i));
    end
  end

  assign hit = |sel;

  always_comb begin
    offset = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) offset = addr - base_of(i);
    end
  end
endmodule

// File: rtl/resp_mux.sv
module resp_mux
  import memmap_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   hit,
  input  logic [NREG-1:0]        sel,
  input  logic [NREG*DATA_W-1:0] rdata_flat,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   rsp_miss
);
  logic [DATA_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) picked = picked | rdata_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_miss  <= req_valid && !hit;
      if (!req_valid || req_write) rsp_rdata <= '0;
      else if (!hit)               rsp_rdata <= '1;
      else                         rsp_rdata <= picked;
    end
  end
endmodule

// File: rtl/mem_region_router.sv
module mem_region_router
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned EXT_BYTES = 10 * 1024 * 1024,
  parameter logic [31:0] DEV_BASE  = 32'hFE00_0000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic [NREG-1:0]        tgt_sel,
  output logic                   tgt_wr,
  output logic [ADDR_W-1:0]      tgt_offset,
  output logic [DATA_W-1:0]      tgt_wdata,
  input  logic [NREG*DATA_W-1:0] tgt_rdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   rsp_miss
);
  logic [NREG-1:0] dec_sel;
  logic            dec_hit;

  addr_decoder #(
    .ADDR_W(ADDR_W), .EXT_BYTES(EXT_BYTES), .DEV_BASE(DEV_BASE)
  ) u_dec (
    .addr(req_addr), .sel(dec_sel), .hit(dec_hit), .offset(tgt_offset)
  );

  assign tgt_sel   = req_valid ? dec_sel : '0;
  assign tgt_wr    = req_valid && req_write && dec_hit && !dec_sel[RG_ROM];
  assign tgt_wdata = req_wdata;

  resp_mux #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .hit(dec_hit), .sel(tgt_sel), .rdata_flat(tgt_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_miss(rsp_miss)
  );
endmodule

// File: rtl/router_chk.sv
module router_chk
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 8,
  parameter logic [31:0] DEV_BASE = 32'hFE00_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [NREG-1:0]   tgt_sel,
  input logic              tgt_wr,
  input logic [ADDR_W-1:0] tgt_offset,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_miss
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_sel));                                            // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (tgt_sel == '0) && !tgt_wr);                    // R8
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    tgt_sel[RG_ROM] |-> !tgt_wr);                                  // R4
  AST_VGA_OFFSET: assert property (@(posedge clk) disable iff (rst)
    tgt_sel[RG_VGA] |-> (tgt_offset < ADDR_W'(32'h2_0000)) &&
                        (req_addr == tgt_offset + ADDR_W'(32'hA_0000))); // R2
  AST_DEV_OFFSET: assert property (@(posedge clk) disable iff (rst)
    tgt_sel[RG_DEV] |-> (req_addr == tgt_offset + ADDR_W'(DEV_BASE)));   // R6
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);                                      // R9
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_miss);                       // R9
  AST_MISS_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && tgt_sel == '0) |=>
      rsp_miss && (rsp_rdata == '1));                              // R7
endmodule

bind mem_region_router router_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_BASE(DEV_BASE)
) u_chk (.*);

// File: tb/sim_mem_region_router.sv
`timescale 1ns/1ps
module sim_mem_region_router;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [7:0]  req_wdata;
  logic [5:0]  tgt_sel;
  logic        tgt_wr;
  logic [31:0] tgt_offset;
  logic [7:0]  tgt_wdata;
  logic [47:0] tgt_rdata;
  logic        rsp_valid, rsp_miss;
  logic [7:0]  rsp_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_region_router u0 (.*);

  // target model: each slot returns a byte derived from offset and slot index
  function automatic logic [7:0] slot_val(int i, logic [31:0] off);
    return off[7:0] ^ off[15:8] ^ 8'(8'h30 + 8'(i * 37));
  endfunction

  // boot ROM model contents may only change if a write strobe reaches it
  logic [7:0] rom_patch;
  logic       rom_touched;
  always_comb begin
    for (int i = 0; i < 6; i++) tgt_rdata[i*8 +: 8] = slot_val(i, tgt_offset);
    if (rom_touched) tgt_rdata[3*8 +: 8] = rom_patch;
  end
  always @(posedge clk) if (tgt_wr && tgt_sel[3]) begin
    rom_touched <= 1'b1;
    rom_patch   <= tgt_wdata;
  end

  function automatic int region_of(logic [31:0] a);
    longint x = longint'(a);
    if (x <= 64'h9FFFF) return 0;
    if (x <= 64'hBFFFF) return 1;
    if (x <= 64'hEFFFF) return 2;
    if (x <= 64'hFFFFF) return 3;
    if (x <= 64'h100000 + 10*1024*1024 - 1) return 4;
    if (x >= 64'hFE000000) return 5;
    return -1;
  endfunction

  function automatic logic [31:0] base_of(int r);
    case (r)
      0: return 32'h0;
      1: return 32'hA0000;
      2: return 32'hC0000;
      3: return 32'hF0000;
      4: return 32'h100000;
      default: return 32'hFE000000;
    endcase
  endfunction

  function automatic string tag_of(int r);
    case (r)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic       exp_v, exp_miss;
  logic [7:0] exp_rd;

  task automatic step(logic v, logic w, logic [31:0] a, logic [7:0] d);
    int r;
    logic [5:0] es;
    @(negedge clk);
    chk("R9", {63'd0, rsp_valid}, {63'd0, exp_v}, "rsp_valid");
    chk("R7", {63'd0, rsp_miss}, {63'd0, exp_miss}, "rsp_miss");
    chk("R9", {56'd0, rsp_rdata}, {56'd0, exp_rd}, "rsp_rdata");
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    #1;
    r  = region_of(a);
    es = (v && r >= 0) ? 6'(1 << r) : 6'd0;
    chk(tag_of(r), {58'd0, tgt_sel}, {58'd0, es}, "tgt_sel");
    chk("R8", {63'd0, tgt_wr}, {63'd0, v && w && r >= 0 && r != 3}, "tgt_wr");
    chk("R8", {56'd0, tgt_wdata}, {56'd0, d}, "tgt_wdata");
    if (v && r >= 0)
      chk(tag_of(r), {32'd0, tgt_offset}, {32'd0, a - base_of(r)}, "tgt_offset");
    exp_v    = v;
    exp_miss = v && r < 0;
    if (!v || w)   exp_rd = 8'h00;
    else if (r < 0) exp_rd = 8'hFF;
    else if (r == 3 && rom_touched) exp_rd = rom_patch;
    else exp_rd = slot_val(r, a - base_of(r));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rom_touched = 1'b0; rom_patch = 8'h00;
    rst = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h1234; req_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: request held during reset produces no response
    chk("R10", {63'd0, rsp_valid}, 64'd0, "rsp_valid in reset");
    chk("R10", {63'd0, rsp_miss}, 64'd0, "rsp_miss in reset");
    chk("R10", {56'd0, rsp_rdata}, 64'd0, "rsp_rdata in reset");
    rst = 1'b0; req_valid = 1'b0;
    exp_v = 0; exp_miss = 0; exp_rd = 0;

    // window edges, reads
    step(1, 0, 32'h0000_0000, 0);  step(1, 0, 32'h0009_FFFF, 0);  // R1
    step(1, 0, 32'h000A_0000, 0);  step(1, 0, 32'h000B_FFFF, 0);  // R2
    step(1, 0, 32'h000C_0000, 0);  step(1, 0, 32'h000E_FFFF, 0);  // R3
    step(1, 0, 32'h000F_0000, 0);  step(1, 0, 32'h000F_FFFF, 0);  // R4
    step(1, 0, 32'h0010_0000, 0);  step(1, 0, 32'h00AF_FFFF, 0);  // R5
    step(1, 0, 32'h00B0_0000, 0);  step(1, 0, 32'hFDFF_FFFF, 0);  // R7
    step(1, 0, 32'hFE00_0000, 0);  step(1, 0, 32'hFFFF_FFFF, 0);  // R6
    step(0, 0, 32'h000A_0010, 0);  step(0, 1, 32'h0000_0040, 8'h5A); // R8 idle
    // writes, including boot ROM protection (R4) and miss writes (R7)
    step(1, 1, 32'h0000_0100, 8'hA5);
    step(1, 1, 32'h000F_1234, 8'hC3);
    step(1, 0, 32'h000F_1234, 0);
    step(1, 1, 32'h00B0_0004, 8'h11);
    step(1, 1, 32'hFE00_0020, 8'h22);
    step(1, 1, 32'h0050_0000, 8'h33);
    // pseudo-random mix
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:1])
        3'd0: step(lfsr[4], lfsr[5], {12'd0, lfsr[27:8]}, lfsr[15:8]);
        3'd1: step(lfsr[4], lfsr[5], {8'd0, lfsr[31:8]}, lfsr[15:8]);
        3'd2: step(1, lfsr[5], {7'h7F, lfsr[31:7]}, lfsr[15:8]);
        default: step(1, lfsr[5], lfsr, lfsr[23:16]);
      endcase
    end
    step(0, 0, 32'h0, 0);
    step(0, 0, 32'h0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule